// File: doc/BRIEF.md
# Sleep-Surviving Watchdog Timer

This block is a watchdog that runs from its own slow, free-running clock. Because that clock does not depend on the main oscillator, the watchdog keeps counting while the device sleeps with the main clock stopped.

Software works it from the main clock domain, using these controls:

- a level enable;
- a clear strobe (`kick`);
- a sleep-entry strobe (`sleep_cmd`), which restarts the watchdog in the same way as a clear;
- a strobe that clears the timeout status flag;
- a 3-bit prescale select.

The count path has two stages. A prescaler of up to 8 bits divides the watchdog clock by 2^`pre_sel`. A timeout counter then counts `BASE_COUNT` prescaled ticks.

At expiry the block does three things:

- it raises a reset request for `HOLD_CYCLES` watchdog clocks;
- it sets a sticky timeout flag;
- it restarts its own count.

Control strobes cross into the watchdog domain through toggle synchronizers. The enable and prescale select cross through two-flop synchronizers.

Top module: `wdt_sleep_guard`

## Requirements
- R1: After reset, `wd_rst_req` and `wd_timeout_flag` are 0.
- R2: With no clear, rising edges of `wd_rst_req` are exactly P = `BASE_COUNT` * 2^`pre_sel` watchdog-clock cycles apart, for every `pre_sel` value 0..7.
- R3: Each reset request stays high for exactly `HOLD_CYCLES` watchdog-clock cycles, then falls.
- R4: `wd_timeout_flag` sets together with each reset request. It stays set after the request ends, and `flag_clr` clears it within 6 watchdog cycles.
- R5: A `kick` restarts both the prescaler and the counter, so the next request rises between P and P+6 watchdog cycles after the kick. Strobes must be at least 4 watchdog cycles apart.
- R6: Kicks issued more often than every P cycles prevent any reset request.
- R7: `sleep_cmd` restarts the watchdog exactly like `kick`. The watchdog then keeps counting and issues its request with the main clock stopped.
- R8: While `wd_enable` is 0, no new request is raised and the count is held at zero. After re-enabling, the first request rises between P and P+6 watchdog cycles later.
- R9: A clear that reaches the counter in the same cycle as expiry wins: no request is raised in that cycle, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock, may stop in sleep |
| rst_main_n | input | 1 | Main-domain async reset, active low |
| wd_enable | input | 1 | Watchdog enable level |
| kick | input | 1 | Clear strobe, one main cycle |
| sleep_cmd | input | 1 | Sleep-entry strobe, one main cycle |
| flag_clr | input | 1 | Timeout flag clear strobe |
| pre_sel | input | 3 | Prescale select, divide by 2^pre_sel |
| clk_wd | input | 1 | Free-running watchdog clock |
| rst_wd_n | input | 1 | Watchdog-domain async reset, active low |
| wd_rst_req | output | 1 | Reset request pulse |
| wd_timeout_flag | output | 1 | Sticky timeout status |

## Verification
A synchronized clear and a counter expiry can land in the same watchdog cycle. The bench provokes this by sweeping the kick instant, one watchdog cycle at a time, across a window that brackets the scheduled expiry. It then measures the gap from the previous request to the next one. That gap must be either exactly P, meaning the clear came too late, or about P past the clear, meaning the clear won; any other gap, an early request or a doubled request, is a failure.

// File: rtl/wdt_sleep_guard.sv
module wdt_sleep_guard #(
  parameter int PRE_W       = 8,
  parameter int SEL_W       = 3,
  parameter int BASE_COUNT  = 4,
  parameter int HOLD_CYCLES = 3
) (
  input  logic             clk_main,
  input  logic             rst_main_n,
  input  logic             wd_enable,
  input  logic             kick,
  input  logic             sleep_cmd,
  input  logic             flag_clr,
  input  logic [SEL_W-1:0] pre_sel,
  input  logic             clk_wd,
  input  logic             rst_wd_n,
  output logic             wd_rst_req,
  output logic             wd_timeout_flag
);
  localparam int CNT_W  = $clog2(BASE_COUNT + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic clr_tgl, fclr_tgl;

  always_ff @(posedge clk_main or negedge rst_main_n)
    if (!rst_main_n) begin
      clr_tgl  <= 1'b0;
      fclr_tgl <= 1'b0;
    end else begin
      if (kick || sleep_cmd) clr_tgl  <= ~clr_tgl;
      if (flag_clr)          fclr_tgl <= ~fclr_tgl;
    end

  logic [2:0]       clr_sync, fclr_sync;
  logic [1:0]       en_sync;
  logic [SEL_W-1:0] sel_s1, sel_s2;

  always_ff @(posedge clk_wd or negedge rst_wd_n)
    if (!rst_wd_n) begin
      clr_sync  <= '0;
      fclr_sync <= '0;
      en_sync   <= '0;
      sel_s1    <= '0;
      sel_s2    <= '0;
    end else begin
      clr_sync  <= {clr_sync[1:0], clr_tgl};
      fclr_sync <= {fclr_sync[1:0], fclr_tgl};
      en_sync   <= {en_sync[0], wd_enable};
      sel_s1    <= pre_sel;
      sel_s2    <= sel_s1;
    end

  wire clr_pulse  = clr_sync[2] ^ clr_sync[1];
  wire fclr_pulse = fclr_sync[2] ^ fclr_sync[1];
  wire en_wd      = en_sync[1];

  logic [PRE_W-1:0]  pre;
  logic [CNT_W-1:0]  cnt;
  logic [HOLD_W-1:0] hold;

  wire [PRE_W-1:0] pre_mask = PRE_W'((32'd1 << sel_s2) - 32'd1);
  wire tick   = en_wd && (pre == pre_mask);
  wire expire = tick && !clr_pulse && (cnt == CNT_W'(BASE_COUNT - 1));

  always_ff @(posedge clk_wd or negedge rst_wd_n)
    if (!rst_wd_n) begin
      pre  <= '0;
      cnt  <= '0;
      hold <= '0;
      wd_timeout_flag <= 1'b0;
    end else begin
      pre <= (!en_wd || clr_pulse || tick) ? '0 : pre + 1'b1;
      if (!en_wd || clr_pulse || expire) cnt <= '0;
      else if (tick)                     cnt <= cnt + 1'b1;
      if (expire)           hold <= HOLD_W'(HOLD_CYCLES);
      else if (hold != '0) hold <= hold - 1'b1;
      if (expire)          wd_timeout_flag <= 1'b1;
      else if (fclr_pulse) wd_timeout_flag <= 1'b0;
    end

  assign wd_rst_req = (hold != '0);
endmodule

module wdt_sleep_guard_chk #(
  parameter int PRE_W       = 8,
  parameter int BASE_COUNT  = 4,
  parameter int HOLD_CYCLES = 3,
  parameter int CNT_W       = 3,
  parameter int HOLD_W      = 2
) (
  input logic              clk_wd,
  input logic              rst_wd_n,
  input logic              en_wd,
  input logic              clr_pulse,
  input logic              fclr_pulse,
  input logic [PRE_W-1:0]  pre,
  input logic [CNT_W-1:0]  cnt,
  input logic [HOLD_W-1:0] hold,
  input logic              wd_rst_req,
  input logic              wd_timeout_flag
);
  assert_cnt_bound_R2: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
    cnt < CNT_W'(BASE_COUNT));
  assert_req_lasts_R3: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
    $rose(wd_rst_req) && HOLD_CYCLES > 1 |=> wd_rst_req);
  assert_hold_bound_R3: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
    hold <= HOLD_W'(HOLD_CYCLES));
  assert_flag_with_req_R4: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
    $rose(wd_rst_req) |-> wd_timeout_flag);
  assert_flag_sticky_R4: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
    wd_timeout_flag && !fclr_pulse |=> wd_timeout_flag);
  assert_clear_restart_R5: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
    clr_pulse |=> (cnt == '0) && (pre == '0) && !$rose(wd_rst_req));
  assert_disabled_idle_R8: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
    !en_wd |=> (cnt == '0) && !$rose(wd_rst_req));
endmodule

bind wdt_sleep_guard wdt_sleep_guard_chk #(
  .PRE_W(PRE_W), .BASE_COUNT(BASE_COUNT), .HOLD_CYCLES(HOLD_CYCLES),
  .CNT_W(CNT_W), .HOLD_W(HOLD_W)
) u_chk (
  .clk_wd(clk_wd), .rst_wd_n(rst_wd_n), .en_wd(en_wd), .clr_pulse(clr_pulse),
  .fclr_pulse(fclr_pulse), .pre(pre), .cnt(cnt), .hold(hold),
  .wd_rst_req(wd_rst_req), .wd_timeout_flag(wd_timeout_flag)
);

// File: tb/test_wdt_sleep_guard.sv
module test_wdt_sleep_guard;
  localparam int BASE = 4;
  localparam int HOLD = 3;

  logic clk_main = 1'b0, clk_wd = 1'b0, main_run = 1'b1;
  logic rst_main_n = 1'b0, rst_wd_n = 1'b0;
  logic wd_enable = 1'b0, kick = 1'b0, sleep_cmd = 1'b0, flag_clr = 1'b0;
  logic [2:0] pre_sel = 3'd0;
  logic wd_rst_req, wd_timeout_flag;

  int checks = 0, errors = 0;
  int wcyc = 0, rise_cnt = 0, last_rise = 0, hcnt = 0, last_hold = 0;
  logic prev_req = 1'b0;

  always begin #2; if (main_run) clk_main = ~clk_main; end
  always #20 clk_wd = ~clk_wd;

  wdt_sleep_guard #(.BASE_COUNT(BASE), .HOLD_CYCLES(HOLD)) i_wdt_sleep_guard (
    .clk_main(clk_main), .rst_main_n(rst_main_n), .wd_enable(wd_enable),
    .kick(kick), .sleep_cmd(sleep_cmd), .flag_clr(flag_clr), .pre_sel(pre_sel),
    .clk_wd(clk_wd), .rst_wd_n(rst_wd_n), .wd_rst_req(wd_rst_req),
    .wd_timeout_flag(wd_timeout_flag));

  always @(negedge clk_wd) begin
    wcyc++;
    if (wd_rst_req && !prev_req) begin rise_cnt++; last_rise = wcyc; end
    if (wd_rst_req) hcnt++;
    else if (hcnt != 0) begin last_hold = hcnt; hcnt = 0; end
    prev_req = wd_rst_req;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wd_wait(input int n);
    repeat (n) @(negedge clk_wd);
  endtask

  task automatic strobe(input int which);
    @(negedge clk_main);
    if (which == 0) kick = 1'b1;
    else if (which == 1) sleep_cmd = 1'b1;
    else flag_clr = 1'b1;
    @(negedge clk_main);
    kick = 1'b0; sleep_cmd = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic wait_rise(output int t);
    int c;
    c = rise_cnt;
    wait (rise_cnt != c);
    t = last_rise;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired actual %0d expected 0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, k, t1, t2, r, c;
    #50;
    check(wd_rst_req == 1'b0, "R1 req", wd_rst_req, 0);
    check(wd_timeout_flag == 1'b0, "R1 flag", wd_timeout_flag, 0);
    rst_main_n = 1'b1; rst_wd_n = 1'b1;
    wd_wait(3);
    check(wd_rst_req == 1'b0 && wd_timeout_flag == 1'b0, "R1 idle after reset", wd_rst_req, 0);
    wd_enable = 1'b1;

    for (int s = 0; s < 8; s++) begin
      p = BASE << s;
      pre_sel = 3'(s);
      wd_wait(3);
      k = wcyc;
      strobe(0);
      wait_rise(t1);
      check(t1 - k >= p && t1 - k <= p + 6, "R5 kick to request", t1 - k, p);
      wait_rise(t2);
      check(t2 - t1 == p, "R2 request period", t2 - t1, p);
      wait (!wd_rst_req); wd_wait(1);
      check(last_hold == HOLD, "R3 hold length", last_hold, HOLD);
      check(wd_timeout_flag == 1'b1, "R4 flag set", wd_timeout_flag, 1);
    end

    pre_sel = 3'd1; p = BASE * 2;
    wd_wait(3);
    c = rise_cnt;
    for (int i = 0; i < 40; i++) begin strobe(0); wd_wait(4); end
    check(rise_cnt == c, "R6 kicks suppress request", rise_cnt - c, 0);

    wait_rise(t1);
    wd_enable = 1'b0;
    wd_wait(10);
    check(wd_timeout_flag == 1'b1 && !wd_rst_req, "R4 flag sticky", wd_timeout_flag, 1);
    strobe(2);
    wd_wait(6);
    check(wd_timeout_flag == 1'b0, "R4 flag cleared", wd_timeout_flag, 0);
    c = rise_cnt;
    wd_wait(200);
    check(rise_cnt == c && !wd_rst_req, "R8 disabled no request", rise_cnt - c, 0);
    check(wd_timeout_flag == 1'b0, "R8 disabled flag stays clear", wd_timeout_flag, 0);
    k = wcyc;
    wd_enable = 1'b1;
    wait_rise(t1);
    check(t1 - k >= p && t1 - k <= p + 6, "R8 re-enable to request", t1 - k, p);

    pre_sel = 3'd3; p = BASE * 8;
    wd_wait(3);
    k = wcyc;
    strobe(1);
    @(posedge clk_main);
    main_run = 1'b0;
    wait_rise(t1);
    check(t1 - k >= p && t1 - k <= p + 6, "R7 sleep request without main clock", t1 - k, p);
    wait (!wd_rst_req); wd_wait(1);
    check(last_hold == HOLD, "R7 hold in sleep", last_hold, HOLD);
    wait_rise(t2);
    check(t2 - t1 == p, "R7 period in sleep", t2 - t1, p);
    main_run = 1'b1;

    pre_sel = 3'd2; p = BASE * 4;
    wd_wait(3);
    for (int off = p - 8; off <= p + 2; off++) begin
      strobe(0);
      wait_rise(r);
      wait (wcyc == r + off);
      strobe(0);
      wait_rise(t1);
      check(t1 - r == p || (t1 - r >= off + p && t1 - r <= off + p + 6),
            "R9 clear versus expiry", t1 - r, p);
      wd_wait(2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule